// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the serial clock for an SD, MMC or SDIO card from the host clock. A divider code selects the rate. The code is one-hot, and the all-zero value is also a legal setting. The zero code gives the fastest rate, host/2. Each single set bit k halves the rate once more per position, so bit 7 gives host/512. The output has a 50% duty cycle. While the block is enabled it toggles all the time, whether or not the card bus carries a command or data.

Three control conditions affect the output. Clearing the enable input drives the card clock low. The freeze input stops the clock at whatever level it has. A code with more than one bit set also stops the clock at its present level. Alongside the clock, the block gives a one-cycle strobe on every host cycle in which the card clock has just risen or fallen. Command and data shifters use this strobe to advance in step with the card clock without sampling it as a clock of their own.

Top module: `sd_clkgen`

## Requirements
- R1: During and directly after reset, `sdclk` and `sdclk_edge` are 0.
- R2: With `clk_en`=1, `freeze`=0 and `div_code`=8'h00, `sdclk` changes level on every host clock cycle (host/2).
- R3: With a code that has only bit k set (k = 0..7), each level of `sdclk` lasts 2^(k+1) host cycles (host/4 for bit 0 up to host/512 for bit 7).
- R4: The high phase and the low phase of `sdclk` have the same length (50% duty).
- R5: When `clk_en` is 0 at a clock edge, `sdclk` is 0 after that edge and `sdclk_edge` stays 0.
- R6: When `clk_en`=1 and `div_code` has two or more bits set, `sdclk` keeps its level and `sdclk_edge` stays 0.
- R7: When `clk_en`=1 and `freeze`=1, `sdclk` keeps its level and `sdclk_edge` stays 0. After `freeze` returns to 0, toggling resumes within one half period plus one cycle.
- R8: `sdclk_edge` is 1 in exactly those cycles in which `sdclk` has just toggled while enabled. It is never 1 in a cycle in which `sdclk` kept its level.
- R9: A change of `div_code` restarts the half-period count. The first edge at the new rate follows the first clock edge that sees the new code by exactly the new half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | 1 = card clock runs, 0 = card clock held low |
| freeze | input | 1 | 1 = card clock stops at its present level |
| div_code | input | 8 | Rate select: 00h = host/2, single bit k = host/2^(k+2), more than one bit = stall |
| sdclk | output | 1 | Card clock |
| sdclk_edge | output | 1 | One-cycle strobe in each cycle in which `sdclk` has just changed |

## Verification
The checker tests several properties on every cycle. It checks that each strobe comes with a real level change, that a toggle under enable always produces a strobe, that a disable forces the clock low, and that a freeze or a multi-bit code holds the level without a strobe. Some behaviour can only be shown by the bench's scenarios. These are the exact half-period length for every code, equal high and low phases, and the restart length after a rate change. They also include the resume after a freeze and the reset state. The bench covers them by measuring the gaps between strobes over directed and random codes.

// File: rtl/sdclk_pkg.sv
// Package: shared constants and the run-mode type for the SD clock generator.
// Assumes: one-hot rate codes with an extra all-zero code; see sd_clkgen.
package sdclk_pkg;

    // Default width of the rate-select code (one bit per doubling step).
    localparam int CODE_W_DEF = 8;

    // Operating mode seen by the counter and the output stage.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,   // output forced low
        MODE_HOLD = 2'd1,   // output kept at its present level
        MODE_RUN  = 2'd2    // output toggles at the selected rate
    } sdclk_mode_e;

endpackage

// File: rtl/sdclk_decode.sv
// Module: sdclk_decode
// Turns the rate-select code into a half-period limit (half period minus one),
// flags codes with more than one set bit, and detects any change of the code.
// Assumes: the code is stable for whole host cycles; limit fits CNT_W bits.
module sdclk_decode #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  half_m1,
    output logic              code_ok,
    output logic              code_new
);

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  step_lim [CODE_W];

    // One term per code bit: bit k stands for a half period of 2^(k+1) cycles.
    genvar k;
    generate
        for (k = 0; k < CODE_W; k++) begin : g_term
            assign step_lim[k] = code[k] ? CNT_W'((2 ** (k + 1)) - 1) : '0;
        end
    endgenerate

    // Merge the per-bit terms; the all-zero code gives a limit of 0 (host/2).
    always_comb begin
        half_m1 = '0;
        for (int i = 0; i < CODE_W; i++) begin
            half_m1 = half_m1 | step_lim[i];
        end
    end

    // A code is usable when at most one bit is set.
    always_comb code_ok = ($countones(code) <= 1);

    // Remember last cycle's code so that a change can restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code;
    end

    // A differing code marks a restart cycle.
    always_comb code_new = (code != code_q);

endmodule

// File: rtl/sdclk_halfcnt.sv
// Module: sdclk_halfcnt
// Counts host cycles within one half period of the card clock and raises
// 'tick' in the cycle where the half period ends.
// Assumes: half_m1 may change at any cycle; a restart or a stall clears the count.
module sdclk_halfcnt
    import sdclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sdclk_mode_e      mode,
    input  logic             restart,
    input  logic [CNT_W-1:0] half_m1,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    // A toggle is due when running, not restarting, and the half period is used up.
    always_comb tick = (mode == MODE_RUN) && !restart && (cnt_q == half_m1);

    // Advance the count, clearing it on a toggle, a restart or any non-run mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (mode != MODE_RUN || restart)    cnt_q <= '0;
        else if (tick)                           cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sdclk_drive.sv
// Module: sdclk_drive
// Holds the card clock level and the edge strobe. The level flips on a tick,
// falls to 0 when off, and stays put otherwise. The strobe marks each flip.
// Assumes: tick is only raised in run mode.
module sdclk_drive
    import sdclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sdclk_mode_e mode,
    input  logic        tick,
    output logic        sdclk,
    output logic        sdclk_edge
);

    // Update the card clock level.
    always_ff @(posedge clk) begin
        if (!rst_n)                sdclk <= 1'b0;
        else if (mode == MODE_OFF) sdclk <= 1'b0;
        else if (tick)             sdclk <= ~sdclk;
    end

    // Register the strobe so it lines up with the new clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sdclk_edge <= 1'b0;
        else        sdclk_edge <= tick && (mode == MODE_RUN);
    end

endmodule

// File: rtl/sd_clkgen.sv
// Module: sd_clkgen (top)
// Card clock generator: the host clock is divided by 2 to 2^(CODE_W+1) under a
// one-hot rate code. Disable forces the output low; freeze or a multi-bit code
// holds its level. A strobe marks every output edge.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module sd_clkgen
    import sdclk_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              freeze,
    input  logic [CODE_W-1:0] div_code,
    output logic              sdclk,
    output logic              sdclk_edge
);

    // Largest half period is 2^CODE_W cycles, so its limit needs CODE_W bits.
    localparam int CNT_W = CODE_W;

    logic [CNT_W-1:0] half_m1;
    logic             code_ok;
    logic             code_new;
    logic             tick;
    sdclk_mode_e      mode;

    // Choose the operating mode from the enable, freeze and code validity.
    always_comb begin
        if (!clk_en)                 mode = MODE_OFF;
        else if (freeze || !code_ok) mode = MODE_HOLD;
        else                         mode = MODE_RUN;
    end

    sdclk_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (div_code),
        .half_m1  (half_m1),
        .code_ok  (code_ok),
        .code_new (code_new)
    );

    sdclk_halfcnt #(.CNT_W(CNT_W)) u_halfcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .restart (code_new),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    sdclk_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .tick       (tick),
        .sdclk      (sdclk),
        .sdclk_edge (sdclk_edge)
    );

endmodule

// File: rtl/sd_clkgen_chk.sv
// Module: sd_clkgen_chk
// Property checker for sd_clkgen, attached to every instance by bind.
// Assumes: it sees only the top-level ports.
module sd_clkgen_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              freeze,
    input logic [CODE_W-1:0] div_code,
    input logic              sdclk,
    input logic              sdclk_edge
);

    // Each strobe comes with a real change of level.
    assert_edge_has_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdclk_edge |-> (sdclk != $past(sdclk)));

    // A level change made while enabled always carries a strobe.
    assert_change_has_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en) && (sdclk != $past(sdclk))) |-> sdclk_edge);

    // Disable forces the output low with no strobe.
    assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (!sdclk && !sdclk_edge));

    // Freeze keeps the level and suppresses the strobe.
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && freeze) |=> ($stable(sdclk) && !sdclk_edge));

    // A multi-bit code keeps the level and suppresses the strobe.
    assert_badcode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !$onehot0(div_code)) |=> ($stable(sdclk) && !sdclk_edge));

endmodule

bind sd_clkgen sd_clkgen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .freeze     (freeze),
    .div_code   (div_code),
    .sdclk      (sdclk),
    .sdclk_edge (sdclk_edge)
);

// File: tb/sd_clkgen_bench.sv
// Bench for sd_clkgen: directed corners plus seeded random rate codes.
module sd_clkgen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clk_en;
    logic       freeze;
    logic [7:0] div_code;
    logic       sdclk;
    logic       sdclk_edge;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    sd_clkgen u_sd_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .freeze     (freeze),
        .div_code   (div_code),
        .sdclk      (sdclk),
        .sdclk_edge (sdclk_edge)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected half period from the requirements (R2, R3).
    function automatic int exp_half(logic [7:0] c);
        if (c == 8'h00) return 1;
        for (int k = 0; k < 8; k++) if (c == (8'h01 << k)) return 2 ** (k + 1);
        return 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Count cycles to the next strobe; flag any level change before it.
    task automatic wait_edge(output int n, output bit early);
        logic lvl0;
        lvl0  = sdclk;
        n     = 0;
        early = 1'b0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (!sdclk_edge && sdclk != lvl0) early = 1'b1;
        end while (!sdclk_edge && n < 4000);
    endtask

    // Run one code and check several half periods against the expectation.
    task automatic run_code(logic [7:0] c);
        int n, h, gap_hi, gap_lo;
        bit early;
        logic lvl;
        h = exp_half(c);
        div_code = c;
        wait_edge(n, early);
        gap_hi = 0;
        gap_lo = 0;
        for (int i = 0; i < 4; i++) begin
            lvl = sdclk;
            wait_edge(n, early);
            chk(n == h, (c == 8'h00) ? "R2 half period" : "R3 half period", n, h);
            chk(sdclk != lvl && !early, "R8 strobe with level change", sdclk, !lvl);
            if (lvl) gap_hi = n; else gap_lo = n;
        end
        chk(gap_hi == gap_lo, "R4 duty", gap_hi, gap_lo);
    endtask

    // Hold check: level stays and no strobe for a number of cycles.
    task automatic expect_hold(string req, logic lvl, int cycles);
        int bad;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sdclk != lvl || sdclk_edge) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            report();
        end
    end

    initial begin
        int n;
        bit early;
        logic lvl;
        logic [7:0] c;
        void'($urandom(32'h5d1c));
        rst_n    = 1'b0;
        clk_en   = 1'b0;
        freeze   = 1'b0;
        div_code = 8'h00;
        repeat (3) @(negedge clk);
        chk(sdclk == 1'b0 && sdclk_edge == 1'b0, "R1 reset state", sdclk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdclk == 1'b0 && sdclk_edge == 1'b0, "R1 after reset", sdclk, 0);

        // R2 and R3: every legal code.
        clk_en = 1'b1;
        run_code(8'h00);
        for (int k = 0; k < 8; k++) run_code(8'h01 << k);

        // Random legal codes.
        for (int i = 0; i < 10; i++) begin
            n = $urandom % 9;
            run_code(n == 8 ? 8'h00 : (8'h01 << n));
        end

        // R9: switch from the slowest rate to /8 mid-period.
        div_code = 8'h80;
        wait_edge(n, early);
        repeat (10) @(negedge clk);
        div_code = 8'h02;
        wait_edge(n, early);
        chk(n == 5, "R9 restart length", n, 5);
        wait_edge(n, early);
        chk(n == 4, "R9 new rate", n, 4);

        // R5: disable while high.
        div_code = 8'h01;
        do @(negedge clk); while (sdclk != 1'b1);
        clk_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sdclk == 1'b0 && !sdclk_edge, "R5 forced low", sdclk, 0);
        expect_hold("R5 stays low", 1'b0, 20);
        clk_en = 1'b1;

        // R6: random multi-bit codes hold either level.
        for (int i = 0; i < 4; i++) begin
            div_code = 8'h04;
            repeat ($urandom % 16) @(negedge clk);
            lvl = sdclk;
            do c = 8'($urandom); while ($countones(c) < 2);
            div_code = c;
            expect_hold("R6 multi-bit hold", lvl, 30);
        end

        // R7: freeze holds, then resumes.
        for (int i = 0; i < 4; i++) begin
            c = 8'h01 << ($urandom % 4);
            div_code = c;
            repeat (3 + $urandom % 16) @(negedge clk);
            lvl = sdclk;
            freeze = 1'b1;
            expect_hold("R7 freeze hold", lvl, 30);
            freeze = 1'b0;
            wait_edge(n, early);
            chk(n <= exp_half(c) + 1, "R7 resume", n, exp_half(c) + 1);
        end

        report();
    end

endmodule